// File: doc/BRIEF.md
# Non-Revertive Reference Selector

This block chooses which of two reference clocks feeds a PLL phase detector and reports that choice back. It drives a select line to an external clock multiplexer and an acknowledge flag that always carries the same value. The block itself has no clock switching logic. Its inputs are three asynchronous control pins: a reference-select pin, an automatic-mode enable and the PLL loss-of-lock indicator.

In manual mode the selection follows the select pin. When the automatic enable is high and the loop reports lock, the selector arms and freezes the selection it had at that moment. A rising loss-of-lock edge while armed flips the selection to the other input once and only once. After that switch the select pin is ignored and further loss-of-lock activity has no effect. To re-arm, the automatic enable must be dropped and raised again. An optional hold-off counter delays arming until lock has been steady for a set number of cycles. All three pins pass through a multi-stage synchronizer, so the outputs react `SYNC_STAGES + 1` clock cycles after a pin change.

The block has no data stream, so none of its pins use a valid/ready handshake. All pins are plain level-sensitive control and status signals.

Top module: `ref_selector_top`

## Requirements
- R1: While in manual mode, `mux_sel_o` takes the value of `ref_sel_i` (0 = input 0, 1 = input 1) exactly `SYNC_STAGES + 1` clock cycles after the pin changes.
- R2: The selector never leaves manual mode while the synchronized loss-of-lock signal is high.
- R3: While armed, a rising edge of the synchronized loss-of-lock signal inverts `mux_sel_o` on the next clock edge and moves the selector into the switched state.
- R4: Only one inversion happens per arming. Any later loss-of-lock edges or levels leave `mux_sel_o` unchanged until manual mode is entered again.
- R5: In the switched state, changes on `ref_sel_i` have no effect on `mux_sel_o`.
- R6: While armed, `mux_sel_o` holds the value captured when arming happened, regardless of `ref_sel_i`. Dropping `auto_en_i` returns to manual mode. Raising it again re-arms with the current `ref_sel_i` value as the new starting reference.
- R7: `ref_ack_o` equals `mux_sel_o` in every cycle.
- R8: If loss-of-lock is already high when `auto_en_i` rises, no switch takes place. A switch needs lock, then arming, then a fresh rising edge.
- R9: Arming happens only after `auto_en_i` high and loss-of-lock low have been seen together for `HOLDOFF_CYCLES + 1` consecutive synchronized cycles. Any break in that run restarts the count.
- R10: After reset the selector is in manual mode with `mux_sel_o` and `ref_ack_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel_i | input | 1 | Manual reference choice (asynchronous) |
| auto_en_i | input | 1 | Automatic-mode enable (asynchronous) |
| lol_i | input | 1 | PLL loss-of-lock indicator, high = unlocked (asynchronous) |
| mux_sel_o | output | 1 | Select line to the reference multiplexer |
| ref_ack_o | output | 1 | Acknowledge of the active reference |

## Verification
The bench builds the block with `SYNC_STAGES = 2` and `HOLDOFF_CYCLES = 5`. With these values the full pin-to-output latency of three cycles can be observed. The hold-off window is short enough that random toggling of the enable and loss-of-lock pins often breaks a run of qualifying cycles partway, and also often lets a run complete. The arming boundary is therefore hit from both sides many times, and the switch, lockout and re-arm paths are all reached within a few thousand cycles.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    ST_MANUAL   = 2'd0,
    ST_ARMED    = 2'd1,
    ST_SWITCHED = 2'd2
  } refsel_state_e;
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= async_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/refsel_holdoff.sv
module refsel_holdoff #(
  parameter int HOLDOFF_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_manual,
  input  logic qualify,
  output logic ready
);
  generate
    if (HOLDOFF_CYCLES == 0) begin : g_direct
      assign ready = qualify;
    end else begin : g_count
      localparam int CW = $clog2(HOLDOFF_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF_CYCLES);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (!in_manual || !qualify) cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end

      assign ready = qualify && (cnt_q == LIMIT);

      AST_HOLDOFF_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_manual && !qualify) |=> !ready); // R9
    end
  endgenerate
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_sel,
  input  logic s_auto,
  input  logic s_lol,
  input  logic arm_ready,
  output logic sel_o,
  output logic in_manual_o
);
  refsel_state_e state_q, state_d;
  logic sel_q, sel_d;
  logic lol_prev_q;
  logic lol_rise;

  assign lol_rise = s_lol && !lol_prev_q;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    unique case (state_q)
      ST_MANUAL: begin
        sel_d = s_sel;
        if (s_auto && !s_lol && arm_ready) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (!s_auto) begin
          state_d = ST_MANUAL;
          sel_d   = s_sel;
        end else if (lol_rise) begin
          state_d = ST_SWITCHED;
          sel_d   = !sel_q;
        end
      end
      ST_SWITCHED: begin
        if (!s_auto) begin
          state_d = ST_MANUAL;
          sel_d   = s_sel;
        end
      end
      default: state_d = ST_MANUAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_MANUAL;
      sel_q      <= 1'b0;
      lol_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      sel_q      <= sel_d;
      lol_prev_q <= s_lol;
    end
  end

  assign sel_o       = sel_q;
  assign in_manual_o = (state_q == ST_MANUAL);

  AST_MANUAL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MANUAL) |=> (sel_q == $past(s_sel))); // R1
  AST_ARM_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MANUAL && s_lol) |=> (state_q == ST_MANUAL)); // R2
  AST_SWITCH_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && s_auto && s_lol && !lol_prev_q)
      |=> (sel_q != $past(sel_q) && state_q == ST_SWITCHED)); // R3
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWITCHED && s_auto) |=> $stable(sel_q)); // R4
  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && s_auto && !(s_lol && !lol_prev_q)) |=> $stable(sel_q)); // R6
endmodule

// File: rtl/ref_selector_top.sv
module ref_selector_top #(
  parameter int SYNC_STAGES    = 2,
  parameter int HOLDOFF_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_sel_i,
  input  logic auto_en_i,
  input  logic lol_i,
  output logic mux_sel_o,
  output logic ref_ack_o
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pins_sync;
  logic s_sel, s_auto, s_lol;
  logic in_manual, arm_ready, sel;

  refsel_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ref_sel_i, auto_en_i, lol_i}),
    .sync_o  (pins_sync)
  );

  assign {s_sel, s_auto, s_lol} = pins_sync;

  refsel_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_manual (in_manual),
    .qualify   (s_auto && !s_lol),
    .ready     (arm_ready)
  );

  refsel_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_sel       (s_sel),
    .s_auto      (s_auto),
    .s_lol       (s_lol),
    .arm_ready   (arm_ready),
    .sel_o       (sel),
    .in_manual_o (in_manual)
  );

  assign mux_sel_o = sel;
  assign ref_ack_o = sel;
endmodule

// File: tb/tb_ref_selector_top.sv
`timescale 1ns/1ps
module tb_ref_selector_top;
  localparam int STG = 2;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_sel_i = 1'b0, auto_en_i = 1'b0, lol_i = 1'b0;
  logic mux_sel_o, ref_ack_o;

  int total = 0, bad = 0;
  string cur_req = "";

  always #4 clk = ~clk;

  ref_selector_top #(.SYNC_STAGES(STG), .HOLDOFF_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .ref_sel_i(ref_sel_i), .auto_en_i(auto_en_i),
    .lol_i(lol_i), .mux_sel_o(mux_sel_o), .ref_ack_o(ref_ack_o)
  );

  // Reference model built from the requirements: 0 manual, 1 armed, 2 switched
  logic [2:0] p1, p2;
  int m_state, m_cnt;
  logic m_sel, m_lolp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0; p2 <= '0; m_state <= 0; m_cnt <= 0; m_sel <= 1'b0; m_lolp <= 1'b0;
    end else begin
      p1 <= {ref_sel_i, auto_en_i, lol_i};
      p2 <= p1;
      m_lolp <= p2[0];
      case (m_state)
        0: begin
          m_sel <= p2[2];
          if (p2[1] && !p2[0]) begin
            if (m_cnt == HOLD) begin m_state <= 1; m_cnt <= 0; end
            else m_cnt <= m_cnt + 1;
          end else m_cnt <= 0;
        end
        1: if (!p2[1]) begin m_state <= 0; m_sel <= p2[2]; end
           else if (p2[0] && !m_lolp) begin m_state <= 2; m_sel <= !m_sel; end
        default: if (!p2[1]) begin m_state <= 0; m_sel <= p2[2]; end
      endcase
    end
  end

  function automatic string model_tag(int st, int cnt);
    if (st == 0) return (cnt > 0) ? "R9" : "R1";
    if (st == 1) return "R6";
    return "R5";
  endfunction

  task automatic check_now();
    string tag = (cur_req != "") ? cur_req : model_tag(m_state, m_cnt);
    total++;
    if (mux_sel_o !== m_sel) begin
      bad++;
      $display("FAIL %s mux_sel_o actual=%b expected=%b t=%0t", tag, mux_sel_o, m_sel, $time);
    end
    total++;
    if (ref_ack_o !== mux_sel_o) begin // R7
      bad++;
      $display("FAIL R7 ref_ack_o actual=%b expected=%b t=%0t", ref_ack_o, mux_sel_o, $time);
    end
  endtask

  task automatic step(input logic s, input logic a, input logic l, input int n, input string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      ref_sel_i = s; auto_en_i = a; lol_i = l;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    cur_req = "R10";
    check_now();
    if (mux_sel_o !== 1'b0) begin bad++; $display("FAIL R10 actual=%b expected=0", mux_sel_o); end
    total++;
    rst_n = 1'b1;
    step(0, 0, 0, 4, "R10");
    step(1, 0, 0, 6, "R1");                // manual follows pin
    step(0, 0, 0, 6, "R1");
    step(0, 1, 0, 3, "R9");                // hold-off run broken early
    step(0, 1, 1, 2, "R2");                // loss-of-lock blocks arming
    step(0, 1, 0, 12, "R9");               // full run, arms
    step(1, 1, 0, 6, "R6");                // pin ignored while armed
    step(1, 1, 1, 6, "R3");                // rising lol switches to 1
    step(1, 1, 0, 4, "R4");
    step(1, 1, 1, 6, "R4");                // second edge: no switch
    step(0, 1, 1, 6, "R5");                // pin ignored after switch
    step(0, 0, 1, 6, "R6");                // back to manual
    step(1, 0, 0, 4, "R6");
    step(1, 1, 0, 12, "R6");               // re-arm with input 1
    step(1, 1, 1, 6, "R3");                // switch to 0
    step(1, 0, 1, 5, "R8");
    step(1, 1, 1, 10, "R8");               // lol already high at auto rise
    step(1, 1, 0, 12, "R8");               // arms, no switch without edge
    step(1, 1, 1, 6, "R8");                // fresh edge switches
    cur_req = "";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      check_now();
      if ($urandom_range(0, 15) == 0) ref_sel_i = ~ref_sel_i;
      if ($urandom_range(0, 40) == 0) auto_en_i = ~auto_en_i;
      if ($urandom_range(0, 9) == 0) lol_i = ~lol_i;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule